// File: doc/BRIEF.md
# Interrupt Controller Status-Read and Poll Command Unit

This block handles the third operational control word of an eight-input programmable interrupt controller. Byte writes to the even command port are decoded, and a write whose select field matches this command word updates three pieces of state. The first is a sticky choice of which status register later reads return. The second is the special mask mode flag. The third is a one-shot poll request. The rest of the controller supplies the request, in-service and mask vectors as inputs.

A read of the even port normally returns the selected status register, either the request vector or the in-service vector. The written control byte is never returned. If a poll is pending, the next even-port read acts as an interrupt acknowledge instead. It returns a byte that encodes the highest-priority eligible request and pulses an acknowledge strobe carrying that level, so that neighbouring logic can move the request into service. An initialization pulse stands for the end of the controller's init sequence and returns the unit to its defaults.

Top module: `pic_ocw3_unit`

## Requirements
- R1: A write is taken as this command only when `port_sel`=0 and data bits 4:3 equal binary 01. Writes to the odd port (`port_sel`=1), and even-port writes with any other value in bits 4:3, change no state.
- R2: Data bits 1:0 of an accepted write set the read selection: 10 selects the request vector and 11 selects the in-service vector. 00 and 01 keep the current selection.
- R3: With no poll pending, an even-port read (`rd_en`=1, `port_sel`=0) loads `rd_data` at the next clock edge with the selected vector. A selection can be read any number of times, and the written control byte is never returned.
- R4: When an accepted write has data bit 5 = 1, data bit 6 becomes the special mask mode state on `smm_active`. When bit 5 = 0, bit 6 is ignored and `smm_active` holds.
- R5: An accepted write with data bit 2 = 1 arms a poll. The next even-port read returns the poll byte instead of a status vector, and the poll is then cleared, so the read after it returns status again.
- R6: The poll byte has bit 7 = 1 and bits 2:0 = the chosen level, with all other bits 0. It is 0x00 when nothing is eligible. Eligible levels are requested and unmasked (irr=1, imr=0) and have a smaller index than the lowest-numbered in-service level. Level 0 has the highest priority.
- R7: While special mask mode is active, in-service levels whose mask bit is 0 do not limit eligibility. Only masked in-service levels block lower-priority requests.
- R8: An acknowledging read that finds a level raises `poll_ack` for exactly one cycle, together with `rd_data`, and `poll_level` carries the same level. An acknowledge that finds nothing gives no pulse.
- R9: A synchronous active-high `rst`, or `init_pulse`, clears special mask mode and any armed poll and selects the request vector. `rst` also clears `rd_data` and `poll_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_pulse | input | 1 | End of controller initialization; restores defaults |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| port_sel | input | 1 | 0 = even command port, 1 = odd port |
| wr_data | input | 8 | Written byte |
| irr | input | 8 | Interrupt request vector |
| isr | input | 8 | In-service vector |
| imr | input | 8 | Mask vector (1 = masked) |
| rd_data | output | 8 | Registered read data |
| smm_active | output | 1 | Special mask mode state |
| poll_ack | output | 1 | One-cycle acknowledge of a poll that found a level |
| poll_level | output | 3 | Level chosen by the acknowledging read |

## Verification
On every cycle, the assertions check that ignored writes leave the mode flag and the read selection alone, that `init_pulse` restores the defaults, and that each acknowledge pulse lasts one cycle and agrees with the poll byte and level. Some behaviour only the scenarios can show. That includes the right vector coming back after a change of selection and the priority choice among pending and in-service levels. It also includes how special mask mode reshapes that choice and whether the poll is disarmed after a single read.

// File: rtl/ocw3_pkg.sv
package ocw3_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [1:0] CMD3_TAG = 2'b01;

  typedef enum logic {SEL_REQ = 1'b0, SEL_SRV = 1'b1} rdsel_e;

  typedef struct packed {
    logic   hit;
    logic   ld_sel;
    rdsel_e sel;
    logic   ld_smm;
    logic   smm;
    logic   poll;
  } cmd3_t;
endpackage

// File: rtl/ocw3_decode.sv
module ocw3_decode
  import ocw3_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          wr_en,
  input  logic          port_sel,
  input  logic [DW-1:0] wr_data,
  output cmd3_t         cmd
);
  logic hit;
  assign hit = wr_en && !port_sel && (wr_data[4:3] == CMD3_TAG);

  always_comb begin
    cmd        = '0;
    cmd.hit    = hit;
    cmd.ld_sel = hit && wr_data[1];
    cmd.sel    = wr_data[0] ? SEL_SRV : SEL_REQ;
    cmd.ld_smm = hit && wr_data[5];
    cmd.smm    = wr_data[6];
    cmd.poll   = hit && wr_data[2];
  end
endmodule

// File: rtl/ocw3_prio.sv
module ocw3_prio #(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  imr,
  input  logic          smm,
  output logic          found,
  output logic [LW-1:0] level
);
  logic [N-1:0] pend, eff_srv, blk, elig;

  assign pend    = irr & ~imr;
  assign eff_srv = smm ? (isr & imr) : isr;

  assign blk[0] = eff_srv[0];
  for (genvar i = 1; i < N; i++) begin : g_blk
    assign blk[i] = blk[i-1] | eff_srv[i];
  end

  assign elig  = pend & ~blk;
  assign found = |elig;

  always_comb begin
    level = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig[k]) level = k[LW-1:0];
    end
  end
endmodule

// File: rtl/pic_ocw3_unit.sv
module pic_ocw3_unit
  import ocw3_pkg::*;
#(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_pulse,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          port_sel,
  input  logic [N-1:0]  wr_data,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  imr,
  output logic [N-1:0]  rd_data,
  output logic          smm_active,
  output logic          poll_ack,
  output logic [LW-1:0] poll_level
);
  cmd3_t        cmd;
  rdsel_e       sel_q;
  logic         smm_q, poll_q, ack_q;
  logic [N-1:0] rd_q;
  logic [LW-1:0] lvl_q;
  logic         p_found;
  logic [LW-1:0] p_level;
  logic [N-1:0] poll_byte;
  logic         rd_even;

  ocw3_decode #(.DW(N)) u_dec (
    .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data), .cmd(cmd)
  );

  ocw3_prio #(.N(N)) u_prio (
    .irr(irr), .isr(isr), .imr(imr), .smm(smm_q),
    .found(p_found), .level(p_level)
  );

  assign rd_even = rd_en && !port_sel;

  always_comb begin
    poll_byte = '0;
    if (p_found) begin
      poll_byte[N-1]    = 1'b1;
      poll_byte[LW-1:0] = p_level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_REQ;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
      ack_q  <= 1'b0;
      lvl_q  <= '0;
      rd_q   <= '0;
    end else if (init_pulse) begin
      sel_q  <= SEL_REQ;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (rd_even) begin
        if (poll_q) begin
          rd_q   <= poll_byte;
          poll_q <= 1'b0;
          ack_q  <= p_found;
          lvl_q  <= p_level;
        end else begin
          rd_q <= (sel_q == SEL_SRV) ? isr : irr;
        end
      end
      if (cmd.ld_sel) sel_q  <= cmd.sel;
      if (cmd.ld_smm) smm_q  <= cmd.smm;
      if (cmd.poll)   poll_q <= 1'b1;
    end
  end

  assign rd_data    = rd_q;
  assign smm_active = smm_q;
  assign poll_ack   = ack_q;
  assign poll_level = lvl_q;

  // R1: ignored writes keep mode flag and selection
  a_r1_ignored_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (port_sel || wr_data[4:3] != CMD3_TAG) && !init_pulse)
      |=> ($stable(smm_active) && $stable(sel_q)));

  // R4: bit 5 clear leaves the mode flag alone
  a_r4_smm_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_sel && wr_data[4:3] == CMD3_TAG && !wr_data[5] && !init_pulse)
      |=> $stable(smm_active));

  // R8: acknowledge is a single-cycle pulse matching the poll byte
  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    poll_ack |=> !poll_ack);
  a_r8_ack_byte: assert property (@(posedge clk) disable iff (rst)
    poll_ack |-> (rd_data[N-1] && rd_data[LW-1:0] == poll_level
                  && rd_data[N-2:LW] == '0));

  // R5: an acknowledge consumes the armed poll
  a_r5_one_shot: assert property (@(posedge clk) disable iff (rst)
    (poll_ack && !$past(cmd.poll)) |-> !poll_q);

  // R9: init pulse restores defaults
  a_r9_init: assert property (@(posedge clk) disable iff (rst)
    init_pulse |=> (!smm_active && !poll_q && sel_q == SEL_REQ && !poll_ack));
endmodule

// File: tb/pic_ocw3_unit_test.sv
module pic_ocw3_unit_test;
  logic clk = 1'b0;
  logic rst, init_pulse, wr_en, rd_en, port_sel;
  logic [7:0] wr_data, irr, isr, imr, rd_data;
  logic smm_active, poll_ack;
  logic [2:0] poll_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  pic_ocw3_unit uut (
    .clk(clk), .rst(rst), .init_pulse(init_pulse), .wr_en(wr_en),
    .rd_en(rd_en), .port_sel(port_sel), .wr_data(wr_data), .irr(irr),
    .isr(isr), .imr(imr), .rd_data(rd_data), .smm_active(smm_active),
    .poll_ack(poll_ack), .poll_level(poll_level)
  );

  // op: 0 idle, 1 write, 2 read | port | data | irr | isr | imr
  localparam int NV = 24;
  localparam logic [34:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'h0B, 8'h00, 8'h00, 8'h00},  // R2 select in-service
    {2'd2, 1'b0, 8'h00, 8'h55, 8'hA0, 8'h00},  // R3
    {2'd2, 1'b0, 8'h00, 8'h55, 8'h0C, 8'h00},  // R3 repeat read
    {2'd1, 1'b0, 8'h08, 8'h00, 8'h00, 8'h00},  // R2 hold (00)
    {2'd2, 1'b0, 8'h00, 8'h11, 8'h22, 8'h00},
    {2'd1, 1'b0, 8'h09, 8'h00, 8'h00, 8'h00},  // R2 hold (01)
    {2'd2, 1'b0, 8'h00, 8'h11, 8'h44, 8'h00},
    {2'd1, 1'b0, 8'h0A, 8'h00, 8'h00, 8'h00},  // R2 select request
    {2'd2, 1'b0, 8'h00, 8'h33, 8'h44, 8'h00},
    {2'd1, 1'b1, 8'h0B, 8'h00, 8'h00, 8'h00},  // R1 odd port
    {2'd2, 1'b0, 8'h00, 8'h5A, 8'hC3, 8'h00},
    {2'd1, 1'b0, 8'h13, 8'h00, 8'h00, 8'h00},  // R1 wrong tag
    {2'd2, 1'b0, 8'h00, 8'h66, 8'h99, 8'h00},
    {2'd1, 1'b0, 8'h68, 8'h00, 8'h00, 8'h00},  // R4 set mode
    {2'd1, 1'b0, 8'h08, 8'h00, 8'h00, 8'h00},  // R4 bit5=0, bit6=0 holds
    {2'd1, 1'b0, 8'h28, 8'h00, 8'h00, 8'h00},  // R4 clear mode
    {2'd1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'h00},  // R5 arm
    {2'd2, 1'b0, 8'h00, 8'h30, 8'h00, 8'h10},  // R6 level 5
    {2'd2, 1'b0, 8'h00, 8'h30, 8'h00, 8'h10},  // R5 back to status
    {2'd1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'h0C, 8'h04, 8'h00},  // R6 blocked -> 00
    {2'd1, 1'b0, 8'h6C, 8'h00, 8'h00, 8'h00},  // R7 mode + arm
    {2'd2, 1'b0, 8'h00, 8'h0C, 8'h04, 8'h00},  // R7 level 2
    {2'd1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'h00}
  };

  bit m_srv, m_smm, m_poll;

  function automatic logic [7:0] poll_ref(input logic [7:0] q, s, m, input bit sm);
    logic [7:0] eff;
    int lim;
    eff = sm ? (s & m) : s;
    lim = 8;
    for (int i = 7; i >= 0; i--) if (eff[i]) lim = i;
    for (int j = 0; j < 8; j++)
      if (j < lim && q[j] && !m[j]) return {1'b1, 4'b0, j[2:0]};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; port_sel = 0; init_pulse = 0; rst = 0;
  endtask

  task automatic run_vec(input logic [34:0] v);
    logic [1:0] op;
    logic pt;
    logic [7:0] d, q, s, m, exp_rd;
    bit exp_ack;
    op = v[34:33]; pt = v[32]; d = v[31:24]; q = v[23:16]; s = v[15:8]; m = v[7:0];
    @(negedge clk);
    idle();
    wr_en = (op == 2'd1); rd_en = (op == 2'd2); port_sel = pt;
    wr_data = d; irr = q; isr = s; imr = m;
    exp_rd = rd_data; exp_ack = 0;
    if (op == 2'd2 && !pt) begin
      if (m_poll) begin
        exp_rd = poll_ref(q, s, m, m_smm);
        exp_ack = exp_rd[7];
        m_poll = 0;
      end else exp_rd = m_srv ? s : q;
    end
    if (op == 2'd1 && !pt && d[4:3] == 2'b01) begin
      if (d[1]) m_srv = d[0];
      if (d[5]) m_smm = d[6];
      if (d[2]) m_poll = 1;
    end
    @(negedge clk);
    idle();
    if (op == 2'd2) check("R3/R5/R6/R7 rd_data", rd_data, exp_rd);
    check("R8 poll_ack", {7'b0, poll_ack}, {7'b0, exp_ack});
    if (exp_ack) check("R8 poll_level", {5'b0, poll_level}, exp_rd & 8'h07);
    check("R1/R4 smm_active", {7'b0, smm_active}, {7'b0, m_smm});
  endtask

  initial begin
    idle(); rst = 1; wr_data = 0; irr = 0; isr = 0; imr = 0;
    repeat (3) @(negedge clk);
    check("R9 reset rd_data", rd_data, 8'h00);
    check("R9 reset smm", {7'b0, smm_active}, 8'h00);
    check("R9 reset ack", {7'b0, poll_ack}, 8'h00);
    rst = 0;
    m_srv = 0; m_smm = 0; m_poll = 0;
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);
    // R7: masked in-service level still blocks in special mask mode
    run_vec({2'd2, 1'b0, 8'h00, 8'h0C, 8'h02, 8'h02});
    run_vec({2'd1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'h00});
    run_vec({2'd2, 1'b0, 8'h00, 8'h0C, 8'h02, 8'h02});
    // R8: pulse lasts one cycle
    run_vec({2'd1, 1'b0, 8'h0C, 8'h00, 8'h00, 8'h00});
    run_vec({2'd2, 1'b0, 8'h00, 8'h01, 8'h00, 8'h00});
    run_vec({2'd0, 1'b0, 8'h00, 8'h01, 8'h00, 8'h00});
    // R9: init pulse clears mode and poll, selects request vector
    run_vec({2'd1, 1'b0, 8'h6F, 8'h00, 8'h00, 8'h00});
    @(negedge clk); init_pulse = 1;
    @(negedge clk); idle();
    m_srv = 0; m_smm = 0; m_poll = 0;
    check("R9 init smm", {7'b0, smm_active}, 8'h00);
    run_vec({2'd2, 1'b0, 8'h00, 8'hE7, 8'h18, 8'h00});
    check("R9 init selects request, poll gone", rd_data, 8'hE7);
    // R9: reset mid-run
    run_vec({2'd1, 1'b0, 8'h6B, 8'h00, 8'h00, 8'h00});
    @(negedge clk); rst = 1;
    @(negedge clk); idle();
    check("R9 reset rd_data cleared", rd_data, 8'h00);
    m_srv = 0; m_smm = 0; m_poll = 0;
    run_vec({2'd2, 1'b0, 8'h00, 8'h3C, 8'hC3, 8'h00});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule